// File: doc/BRIEF.md
# Accumulator ALU with Flag Masking

This block is the execute stage of an 8-bit processor datapath. Each cycle it may take an operation code, the accumulator, an operand and the current four-flag status byte, and one clock later it presents a result, a result-write strobe and an updated status byte. It covers eight two-input accumulator operations, 8-bit increment and decrement of the operand, a 16-bit add into the HL register pair, four accumulator rotates, decimal adjust, accumulator complement, and the set-carry and invert-carry operations.

Every operation has its own flag-update mask. A flag bit inside the mask takes the freshly computed value. A bit outside the mask keeps the value from the incoming status byte. Operand fetch, register-file write-back and instruction decode sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: All outputs are registered and appear one clock after the operation is presented. While synchronous reset is active, `res_out` is 0, `res_we` is 0 and `flags_out` is 0.
- R2: The status byte has zero in bit 7 (0x80), subtract in bit 6 (0x40), half-carry in bit 5 (0x20) and carry in bit 4 (0x10). Bits 3..0 of `flags_out` are always 0, whatever arrives on `flags_in`.
- R3: ADD (code 0) and ADC (code 1) write acc+opnd (+carry for ADC) into the low byte of the result. Zero is set when the 8-bit result is 0. Subtract is cleared. Half-carry is the carry out of bit 3. Carry is the carry out of bit 7.
- R4: SUB (code 2) and SBC (code 3) write acc-opnd (-carry for SBC). Subtract is set. Half-carry is the borrow from bit 4. Carry is the borrow out of bit 7. Zero is set as in R3.
- R5: AND (code 4) sets half-carry. XOR (code 5) and OR (code 6) clear half-carry. All three clear subtract and carry and set zero from the result.
- R6: CP (code 7) updates all flags exactly as SUB does, with `res_we` held at 0.
- R7: INC (code 8) and DEC (code 9) add or subtract 1 from the operand byte and write the sum or difference. They update zero, subtract and half-carry, and keep the incoming carry.
- R8: ADD16 (code 10) writes the 16-bit sum hl_in+opnd_in. It keeps zero, clears subtract, takes half-carry from the carry out of bit 11 and takes carry from the carry out of bit 15.
- R9: The rotates RLCA (11), RLA (12), RRCA (13) and RRA (14) rotate the accumulator left or right. In the plain rotates the outgoing bit wraps around. In RLA and RRA the old carry enters the vacated bit. Carry receives the bit shifted out. Subtract and half-carry are cleared, and zero is always forced to 0.
- R10: DAA (code 15) corrects the accumulator to packed BCD after an add or a subtract, using the incoming subtract, half-carry and carry. It keeps subtract, clears half-carry, sets zero from the result and sets carry on a decimal overflow.
- R11: CPL (code 16) writes the inverted accumulator and sets subtract and half-carry. Zero and carry are kept.
- R12: SCF (code 17) sets carry and CCF (code 18) inverts carry. Both clear subtract and half-carry, keep zero and hold `res_we` at 0.
- R13: With `op_valid` low, or with an unused code (19..31), `res_we` is 0 and `flags_out` equals `flags_in` with bits 3..0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 16 | Operand: low byte for 8-bit operations, full word for ADD16 |
| hl_in | input | 16 | HL pair value for ADD16 |
| flags_in | input | 8 | Current status byte |
| res_out | output | 16 | Result, zero-extended for 8-bit operations |
| res_we | output | 1 | Result is to be written back |
| flags_out | output | 8 | Updated status byte |

## Verification
Result, write strobe and status byte all come from one register stage. Each is therefore due exactly one rising edge after its inputs were applied. The bench applies every operation on a falling edge and compares all three outputs on the next falling edge, after exactly one rising edge. Each case holds its inputs for a single cycle, so a wrong latency shows up as the neighbouring case's values. Idle cycles and unused codes are checked in the same way: on the cycle after that stimulus, the bench compares the flags output against the incoming status byte.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths, flag bit positions and operation codes of the
// accumulator ALU. Assumes an 8-bit data path with a 16-bit pair add.
package acc_alu_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NIB_W   = BYTE_W / 2;
    localparam int OP_W    = 5;

    // Status byte bit positions
    localparam int FZ = 7;
    localparam int FN = 6;
    localparam int FH = 5;
    localparam int FC = 4;
    localparam logic [BYTE_W-1:0] FLAG_BITS = 8'hF0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_AND   = 5'd4,
        OP_XOR   = 5'd5,
        OP_OR    = 5'd6,
        OP_CP    = 5'd7,
        OP_INC   = 5'd8,
        OP_DEC   = 5'd9,
        OP_ADD16 = 5'd10,
        OP_RLCA  = 5'd11,
        OP_RLA   = 5'd12,
        OP_RRCA  = 5'd13,
        OP_RRA   = 5'd14,
        OP_DAA   = 5'd15,
        OP_CPL   = 5'd16,
        OP_SCF   = 5'd17,
        OP_CCF   = 5'd18
    } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
// Module: 8-bit adder/subtractor with carry-in.
// Produces the byte result, the carry/borrow out of the low nibble and the
// carry/borrow out of the top bit. Purely combinational.
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [BYTE_W-1:0] r,
    output logic              half,
    output logic              carry
);
    logic [BYTE_W:0] full_w;
    logic [NIB_W:0]  nib_w;

    // Full-width and nibble-width sum or difference, carry/borrow in the top bit.
    always_comb begin
        if (sub) begin
            full_w = {1'b0, a} - {1'b0, b} - {{BYTE_W{1'b0}}, cin};
            nib_w  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
        end else begin
            full_w = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, cin};
            nib_w  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        end
    end

    assign r     = full_w[BYTE_W-1:0];
    assign carry = full_w[BYTE_W];
    assign half  = nib_w[NIB_W];
endmodule

// File: rtl/acc_alu_unary.sv
// Module: single-operand accumulator operations (rotates, decimal adjust,
// complement). Returns the new byte and the carry the operation produces.
// Assumes the caller applies the flag mask. Combinational.
module acc_alu_unary
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] f,
    output logic [BYTE_W-1:0] r,
    output logic              carry
);
    logic [BYTE_W-1:0] corr;
    logic              dec_ovf;

    // Decimal correction amount and decimal overflow from the incoming flags.
    always_comb begin
        corr    = '0;
        dec_ovf = f[FC];
        if (!f[FN]) begin
            if (f[FH] || (a[NIB_W-1:0] > 4'd9)) corr[NIB_W-1:0] = 4'h6;
            if (f[FC] || (a > 8'h99)) begin
                corr[BYTE_W-1:NIB_W] = 4'h6;
                dec_ovf = 1'b1;
            end
        end else begin
            if (f[FH]) corr[NIB_W-1:0] = 4'h6;
            if (f[FC]) corr[BYTE_W-1:NIB_W] = 4'h6;
        end
    end

    // Result and carry selection per operation.
    always_comb begin
        r     = a;
        carry = f[FC];
        case (op)
            OP_RLCA: begin r = {a[BYTE_W-2:0], a[BYTE_W-1]}; carry = a[BYTE_W-1]; end
            OP_RLA:  begin r = {a[BYTE_W-2:0], f[FC]};       carry = a[BYTE_W-1]; end
            OP_RRCA: begin r = {a[0], a[BYTE_W-1:1]};        carry = a[0];        end
            OP_RRA:  begin r = {f[FC], a[BYTE_W-1:1]};       carry = a[0];        end
            OP_DAA:  begin r = f[FN] ? (a - corr) : (a + corr); carry = dec_ovf;  end
            OP_CPL:  r = ~a;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_flagmerge.sv
// Module: per-bit merge of computed flags into the old status byte under a
// mask. Bits outside the flag field are forced to 0. Combinational.
module acc_alu_flagmerge
    import acc_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] fresh,
    input  logic [BYTE_W-1:0] mask,
    input  logic [BYTE_W-1:0] old,
    output logic [BYTE_W-1:0] merged
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (FLAG_BITS[i]) begin : g_flag
            assign merged[i] = mask[i] ? fresh[i] : old[i];
        end else begin : g_zero
            assign merged[i] = 1'b0;
        end
    end
endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU with per-operation flag masking.
// Decodes the operation code into a computed flag byte, an update mask and a
// write strobe, then registers result, strobe and merged flags.
// Assumes operands are stable when op_valid is high; one-cycle latency.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic [WORD_W-1:0] opnd_in,
    input  logic [WORD_W-1:0] hl_in,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [WORD_W-1:0] res_out,
    output logic              res_we,
    output logic [BYTE_W-1:0] flags_out
);
    localparam int LOW12 = 3 * NIB_W;

    logic [BYTE_W-1:0] as_a, as_b, as_r;
    logic              as_cin, as_sub, as_h, as_c;
    logic [BYTE_W-1:0] un_r;
    logic              un_c;
    logic [WORD_W:0]   w_sum;
    logic [LOW12:0]    w_low;
    logic [BYTE_W-1:0] fresh, mask, merged;
    logic [WORD_W-1:0] res_d;
    logic              we_d;
    logic              is_incdec;

    // Operand steering for the shared adder/subtractor.
    always_comb begin
        is_incdec = (op_sel == OP_INC) || (op_sel == OP_DEC);
        as_a   = is_incdec ? opnd_in[BYTE_W-1:0] : acc_in;
        as_b   = is_incdec ? 8'd1 : opnd_in[BYTE_W-1:0];
        as_cin = ((op_sel == OP_ADC) || (op_sel == OP_SBC)) && flags_in[FC];
        as_sub = (op_sel == OP_SUB) || (op_sel == OP_SBC) ||
                 (op_sel == OP_CP)  || (op_sel == OP_DEC);
    end

    acc_alu_addsub u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .half(as_h), .carry(as_c)
    );

    acc_alu_unary u_unary (
        .op(op_sel), .a(acc_in), .f(flags_in), .r(un_r), .carry(un_c)
    );

    // 16-bit pair add with carry taps at bit 11 and bit 15.
    always_comb begin
        w_sum = {1'b0, hl_in} + {1'b0, opnd_in};
        w_low = {1'b0, hl_in[LOW12-1:0]} + {1'b0, opnd_in[LOW12-1:0]};
    end

    // Per-operation result, write strobe, computed flags and update mask.
    always_comb begin
        res_d = '0;
        we_d  = 1'b0;
        fresh = '0;
        mask  = '0;
        if (op_valid) begin
            case (op_sel)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP: begin
                    res_d     = {{BYTE_W{1'b0}}, as_r};
                    we_d      = (op_sel != OP_CP);
                    fresh[FZ] = (as_r == '0);
                    fresh[FN] = as_sub;
                    fresh[FH] = as_h;
                    fresh[FC] = as_c;
                    mask      = FLAG_BITS;
                end
                OP_AND, OP_XOR, OP_OR: begin
                    if (op_sel == OP_AND)      res_d[BYTE_W-1:0] = acc_in & opnd_in[BYTE_W-1:0];
                    else if (op_sel == OP_XOR) res_d[BYTE_W-1:0] = acc_in ^ opnd_in[BYTE_W-1:0];
                    else                       res_d[BYTE_W-1:0] = acc_in | opnd_in[BYTE_W-1:0];
                    we_d      = 1'b1;
                    fresh[FZ] = (res_d[BYTE_W-1:0] == '0);
                    fresh[FH] = (op_sel == OP_AND);
                    mask      = FLAG_BITS;
                end
                OP_INC, OP_DEC: begin
                    res_d     = {{BYTE_W{1'b0}}, as_r};
                    we_d      = 1'b1;
                    fresh[FZ] = (as_r == '0);
                    fresh[FN] = as_sub;
                    fresh[FH] = as_h;
                    mask      = FLAG_BITS & ~(8'h1 << FC);
                end
                OP_ADD16: begin
                    res_d     = w_sum[WORD_W-1:0];
                    we_d      = 1'b1;
                    fresh[FH] = w_low[LOW12];
                    fresh[FC] = w_sum[WORD_W];
                    mask      = FLAG_BITS & ~(8'h1 << FZ);
                end
                OP_RLCA, OP_RLA, OP_RRCA, OP_RRA: begin
                    res_d     = {{BYTE_W{1'b0}}, un_r};
                    we_d      = 1'b1;
                    fresh[FC] = un_c;
                    mask      = FLAG_BITS;
                end
                OP_DAA: begin
                    res_d     = {{BYTE_W{1'b0}}, un_r};
                    we_d      = 1'b1;
                    fresh[FZ] = (un_r == '0);
                    fresh[FC] = un_c;
                    mask      = FLAG_BITS & ~(8'h1 << FN);
                end
                OP_CPL: begin
                    res_d     = {{BYTE_W{1'b0}}, un_r};
                    we_d      = 1'b1;
                    fresh[FN] = 1'b1;
                    fresh[FH] = 1'b1;
                    mask      = (8'h1 << FN) | (8'h1 << FH);
                end
                OP_SCF, OP_CCF: begin
                    fresh[FC] = (op_sel == OP_SCF) ? 1'b1 : ~flags_in[FC];
                    mask      = (8'h1 << FN) | (8'h1 << FH) | (8'h1 << FC);
                end
                default: ;
            endcase
        end
    end

    acc_alu_flagmerge u_merge (
        .fresh(fresh), .mask(mask), .old(flags_in), .merged(merged)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out   <= '0;
            res_we    <= 1'b0;
            flags_out <= '0;
        end else begin
            res_out   <= res_d;
            res_we    <= we_d;
            flags_out <= merged;
        end
    end

    // R6
    cp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CP) |=> !res_we);

    // R13
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_we && flags_out[FZ] == $past(flags_in[FZ])));

    // R7
    incdec_carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_INC || op_sel == OP_DEC))
        |=> flags_out[FC] == $past(flags_in[FC]));

    // R8
    add16_zero_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_ADD16)
        |=> (flags_out[FZ] == $past(flags_in[FZ]) && !flags_out[FN]));

    // R9
    rotate_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= OP_RLCA && op_sel <= OP_RRA) |=> !flags_out[FZ]);

    // R11
    cpl_sets_nh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CPL) |=> (flags_out[FN] && flags_out[FH]));
endmodule

// File: tb/acc_alu_test.sv
// Directed bench for acc_alu: one task per scenario, expected values worked
// out by hand from the requirements.
module acc_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [7:0]  acc_in = '0;
    logic [15:0] opnd_in = '0;
    logic [15:0] hl_in = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] res_out;
    logic        res_we;
    logic [7:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .hl_in(hl_in), .flags_in(flags_in),
        .res_out(res_out), .res_we(res_we), .flags_out(flags_out)
    );

    task automatic cmp(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Apply one operation on a falling edge, sample on the next falling edge.
    task automatic apply(input bit v, input logic [4:0] op, input logic [7:0] a,
                         input logic [15:0] b, input logic [15:0] hl, input logic [7:0] f);
        @(negedge clk);
        op_valid = v; op_sel = op; acc_in = a; opnd_in = b; hl_in = hl; flags_in = f;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic op_full(input string tag, input logic [4:0] op, input logic [7:0] a,
                           input logic [15:0] b, input logic [15:0] hl, input logic [7:0] f,
                           input int exp_res, input int exp_we, input int exp_f);
        apply(1'b1, op, a, b, hl, f);
        if (exp_we != 0) cmp({tag, " result"}, res_out, exp_res);
        cmp({tag, " write"}, res_we, exp_we);
        cmp({tag, " flags"}, flags_out, exp_f);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R1 reset result", res_out, 0);
        cmp("R1 reset write", res_we, 0);
        cmp("R1 reset flags", flags_out, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        op_full("R3 ADD wrap", 5'd0, 8'h3A, 16'h00C6, 0, 8'h00, 16'h0000, 1, 8'hB0);
        op_full("R3 ADC cin", 5'd1, 8'h0F, 16'h0000, 0, 8'h10, 16'h0010, 1, 8'h20);
        op_full("R2 ADD low nibble cleared", 5'd0, 8'h01, 16'h0001, 0, 8'h0F, 16'h0002, 1, 8'h00);
    endtask

    task automatic t_sub();
        op_full("R4 SUB half borrow", 5'd2, 8'h3E, 16'h000F, 0, 8'h00, 16'h002F, 1, 8'h60);
        op_full("R4 SBC borrow", 5'd3, 8'h10, 16'h0010, 0, 8'h10, 16'h00FF, 1, 8'h70);
    endtask

    task automatic t_logic();
        op_full("R5 AND zero", 5'd4, 8'h5A, 16'h00A5, 0, 8'h50, 16'h0000, 1, 8'hA0);
        op_full("R5 XOR", 5'd5, 8'hFF, 16'h000F, 0, 8'hF0, 16'h00F0, 1, 8'h00);
        op_full("R5 OR zero", 5'd6, 8'h00, 16'h0000, 0, 8'h70, 16'h0000, 1, 8'h80);
    endtask

    task automatic t_cp();
        op_full("R6 CP", 5'd7, 8'h3C, 16'h0040, 0, 8'h00, 0, 0, 8'h50);
    endtask

    task automatic t_incdec();
        op_full("R7 INC wrap keep C", 5'd8, 8'h00, 16'h00FF, 0, 8'h10, 16'h0000, 1, 8'hB0);
        op_full("R7 INC half", 5'd8, 8'h00, 16'h000F, 0, 8'h00, 16'h0010, 1, 8'h20);
        op_full("R7 DEC zero", 5'd9, 8'h00, 16'h0001, 0, 8'h00, 16'h0000, 1, 8'hC0);
        op_full("R7 DEC wrap keep C", 5'd9, 8'h00, 16'h0000, 0, 8'h10, 16'h00FF, 1, 8'h70);
    endtask

    task automatic t_add16();
        op_full("R8 ADD16 both carries", 5'd10, 8'h00, 16'h8A23, 16'h8A23, 8'hC0, 16'h1446, 1, 8'hB0);
        op_full("R8 ADD16 bit11 only", 5'd10, 8'h00, 16'h0001, 16'h0FFF, 8'h50, 16'h1000, 1, 8'h20);
    endtask

    task automatic t_rot();
        op_full("R9 RLCA", 5'd11, 8'h80, 0, 0, 8'hE0, 16'h0001, 1, 8'h10);
        op_full("R9 RLA zero forced low", 5'd12, 8'h80, 0, 0, 8'h00, 16'h0000, 1, 8'h10);
        op_full("R9 RRCA", 5'd13, 8'h01, 0, 0, 8'h00, 16'h0080, 1, 8'h10);
        op_full("R9 RRA carry in", 5'd14, 8'h01, 0, 0, 8'h10, 16'h0080, 1, 8'h10);
        op_full("R9 RRA zero result", 5'd14, 8'h00, 0, 0, 8'h80, 16'h0000, 1, 8'h00);
    endtask

    task automatic t_daa();
        op_full("R10 DAA after add", 5'd15, 8'h7D, 0, 0, 8'h00, 16'h0083, 1, 8'h00);
        op_full("R10 DAA after sub", 5'd15, 8'h0D, 0, 0, 8'h60, 16'h0007, 1, 8'h40);
        op_full("R10 DAA overflow", 5'd15, 8'h9A, 0, 0, 8'h00, 16'h0000, 1, 8'h90);
    endtask

    task automatic t_cpl();
        op_full("R11 CPL keep ZC", 5'd16, 8'h35, 0, 0, 8'h90, 16'h00CA, 1, 8'hF0);
        op_full("R11 CPL", 5'd16, 8'h00, 0, 0, 8'h00, 16'h00FF, 1, 8'h60);
    endtask

    task automatic t_carry_ops();
        op_full("R12 SCF", 5'd17, 8'h00, 0, 0, 8'hE0, 0, 0, 8'h90);
        op_full("R12 CCF clear", 5'd18, 8'h00, 0, 0, 8'h70, 0, 0, 8'h00);
        op_full("R12 CCF set", 5'd18, 8'h00, 0, 0, 8'h80, 0, 0, 8'h90);
    endtask

    task automatic t_idle();
        apply(1'b0, 5'd0, 8'h11, 16'h0022, 0, 8'hAF);
        cmp("R13 idle write", res_we, 0);
        cmp("R13 idle flags", flags_out, 8'hA0);
        op_full("R13 unused code", 5'd31, 8'h11, 16'h0022, 0, 8'h5F, 0, 0, 8'h50);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_cp();
        t_incdec();
        t_add16();
        t_rot();
        t_daa();
        t_cpl();
        t_carry_ops();
        t_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule